// File: doc/BRIEF.md
# Dual-Buffer Configuration Command Port

This block is the configuration side of a memory whose sequential port walks through two buffers. A random-access host reaches it by pulling the command strobe low while holding chip enable high. A 3-bit register code and a read/write line then pick one of eight slots:

- four 13-bit buffer boundary registers;
- a flow-control register that holds a 2-bit traversal mode for each buffer;
- a slot that clears the end-of-buffer flags on a write and returns their status on a read;
- two reserved slots.

Writes use a 16-bit data bus with active-low lower and upper byte enables. Register contents and mode fields leave the block as plain levels. Flag clears leave it as single-cycle pulses. All of these go to the sequential pointer logic, which sits outside this block along with the memory array.

Reads are combinational: while a read access is held, `rdata` shows the selected slot. Any bit that the slot does not define reads as one. Writes take effect on the rising clock edge. Reset is asynchronous and loads a fixed partition: the lower half of the address space is buffer 1, the upper half is buffer 2, and both buffers are in chaining mode.

Top module: `bcr_top`

## Requirements
- R1: An access happens only while `cmd_n` is 0 and `ce` is 1. Otherwise no register changes, no clear pulse is produced, and `rdata` is all ones.
- R2: Codes 0, 1, 2 and 3 write the buffer 1 start, buffer 1 end, buffer 2 start and buffer 2 end registers from `wdata[12:0]`. A read of these codes returns the register in bits 12..0 and ones in bits 15..13.
- R3: Code 4 (flow control) holds the buffer 1 mode in bits 1..0 and the buffer 2 mode in bits 3..2, with 00 chain, 01 stop, 10 linear and 11 mask. A read returns ones in bits 15..4.
- R4: A write to code 5 with bit 0 set raises `clr_eob1`, and with bit 1 set raises `clr_eob2`. Each pulse is high for exactly the one cycle after the clock edge that accepted the write. The clear write changes no register.
- R5: A read of code 5 returns `eob1_flag` in bit 0, `eob2_flag` in bit 1 and ones in bits 15..2.
- R6: Codes 6 and 7 are reserved. Writes to them have no effect, and reads from them return all ones.
- R7: After reset, the buffer 1 start is 0, the buffer 1 end is 4095, the buffer 2 start is 4096, the buffer 2 end is 8191, both modes are 00, and both clear outputs are 0.
- R8: `lb_n` = 0 enables writing bits 7..0 and `ub_n` = 0 enables writing bits 15..8 of the selected register. A write with both high changes nothing. Flow-control and clear bits lie in the lower byte, so they need `lb_n` = 0.
- R9: Reset acts as soon as `rst_n` falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_n | input | 1 | Command strobe, active low |
| ce | input | 1 | Chip enable, must be 1 during command access |
| rd_wr | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 3 | Register code |
| lb_n | input | 1 | Lower byte enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, all ones when no read access is active |
| eob1_flag | input | 1 | Buffer 1 end flag from the pointer logic |
| eob2_flag | input | 1 | Buffer 2 end flag from the pointer logic |
| buf1_start | output | 13 | Buffer 1 start address |
| buf1_end | output | 13 | Buffer 1 end address |
| buf2_start | output | 13 | Buffer 2 start address |
| buf2_end | output | 13 | Buffer 2 end address |
| buf1_mode | output | 2 | Buffer 1 flow mode |
| buf2_mode | output | 2 | Buffer 2 flow mode |
| clr_eob1 | output | 1 | One-cycle clear pulse for flag 1 |
| clr_eob2 | output | 1 | One-cycle clear pulse for flag 2 |

## Verification
A clear pulse is still high in the cycle after the clear write. In that same cycle the host may already be writing or reading another register. The bench provokes this overlap by issuing a clear write immediately followed by a boundary write, then a status read, with no idle cycle between them. It then checks three things: that the pulse lasts exactly one cycle, that the second write lands unchanged, and that the status read reflects the flag inputs rather than the pending clear. Randomly mixed operations produce further overlaps of the same kind, and each is judged against the bench's own register model.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    typedef enum logic [1:0] {
        FLOW_CHAIN  = 2'b00,
        FLOW_STOP   = 2'b01,
        FLOW_LINEAR = 2'b10,
        FLOW_MASK   = 2'b11
    } flow_e;

    localparam int NCODE = 8;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] C_S1   = 3'd0;
    localparam logic [CODE_W-1:0] C_E1   = 3'd1;
    localparam logic [CODE_W-1:0] C_S2   = 3'd2;
    localparam logic [CODE_W-1:0] C_E2   = 3'd3;
    localparam logic [CODE_W-1:0] C_FLOW = 3'd4;
    localparam logic [CODE_W-1:0] C_FLAG = 3'd5;
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
(
    input  logic              cmd_n,
    input  logic              ce,
    input  logic              rd_wr,
    input  logic [CODE_W-1:0] cmd_addr,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [NCODE-1:0]  sel
);
    logic acc;

    assign acc    = !cmd_n && ce;
    assign acc_rd = acc && rd_wr;
    assign acc_wr = acc && !rd_wr;

    for (genvar g = 0; g < NCODE; g++) begin : g_sel
        assign sel[g] = acc && (cmd_addr == CODE_W'(g));
    end

    always_comb begin
        assert ($onehot0(sel)); // R1
    end
endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
    import bcr_pkg::*;
#(
    parameter int PW = 13,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_rd,
    input  logic [NCODE-1:0] sel,
    input  logic [PW-1:0]    s1,
    input  logic [PW-1:0]    e1,
    input  logic [PW-1:0]    s2,
    input  logic [PW-1:0]    e2,
    input  logic [1:0]       m1,
    input  logic [1:0]       m2,
    input  logic             f1,
    input  logic             f2,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '1;
        if (acc_rd) begin
            if (sel[C_S1])   rdata[PW-1:0] = s1;
            if (sel[C_E1])   rdata[PW-1:0] = e1;
            if (sel[C_S2])   rdata[PW-1:0] = s2;
            if (sel[C_E2])   rdata[PW-1:0] = e2;
            if (sel[C_FLOW]) rdata[3:0]    = {m2, m1};
            if (sel[C_FLAG]) rdata[1:0]    = {f2, f1};
        end
    end

    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |-> (rdata == '1)); // R1
    AST_RSV_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && (sel[6] || sel[7])) |-> (rdata == '1)); // R6
endmodule

// File: rtl/bcr_top.sv
module bcr_top
    import bcr_pkg::*;
#(
    parameter int PW = 13,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_n,
    input  logic              ce,
    input  logic              rd_wr,
    input  logic [CODE_W-1:0] cmd_addr,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              eob1_flag,
    input  logic              eob2_flag,
    output logic [PW-1:0]     buf1_start,
    output logic [PW-1:0]     buf1_end,
    output logic [PW-1:0]     buf2_start,
    output logic [PW-1:0]     buf2_end,
    output logic [1:0]        buf1_mode,
    output logic [1:0]        buf2_mode,
    output logic              clr_eob1,
    output logic              clr_eob2
);
    localparam int BYTE_W = 8;
    localparam logic [PW-1:0] RST_S1 = '0;
    localparam logic [PW-1:0] RST_S2 = PW'(1) << (PW - 1);
    localparam logic [PW-1:0] RST_E1 = RST_S2 - PW'(1);
    localparam logic [PW-1:0] RST_E2 = '1;

    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] e1;
        logic [PW-1:0] s2;
        logic [PW-1:0] e2;
        logic [1:0]    m1;
        logic [1:0]    m2;
        logic          c1;
        logic          c2;
    } st_t;

    st_t st_d, st_q;
    logic acc_rd, acc_wr;
    logic [NCODE-1:0] sel;

    function automatic logic [PW-1:0] merge_bytes(input logic [PW-1:0] old,
                                                   input logic [DW-1:0] wd,
                                                   input logic lo_en,
                                                   input logic hi_en);
        logic [PW-1:0] r;
        r = old;
        for (int i = 0; i < PW; i++) begin
            if ((i < BYTE_W) ? lo_en : hi_en) r[i] = wd[i];
        end
        return r;
    endfunction

    bcr_decode u_dec (
        .cmd_n    (cmd_n),
        .ce       (ce),
        .rd_wr    (rd_wr),
        .cmd_addr (cmd_addr),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .sel      (sel)
    );

    always_comb begin
        logic lo_en, hi_en;
        lo_en = !lb_n;
        hi_en = !ub_n;
        st_d    = st_q;
        st_d.c1 = 1'b0;
        st_d.c2 = 1'b0;
        if (acc_wr) begin
            if (sel[C_S1]) st_d.s1 = merge_bytes(st_q.s1, wdata, lo_en, hi_en);
            if (sel[C_E1]) st_d.e1 = merge_bytes(st_q.e1, wdata, lo_en, hi_en);
            if (sel[C_S2]) st_d.s2 = merge_bytes(st_q.s2, wdata, lo_en, hi_en);
            if (sel[C_E2]) st_d.e2 = merge_bytes(st_q.e2, wdata, lo_en, hi_en);
            if (sel[C_FLOW] && lo_en) begin
                st_d.m1 = wdata[1:0];
                st_d.m2 = wdata[3:2];
            end
            if (sel[C_FLAG] && lo_en) begin
                st_d.c1 = wdata[0];
                st_d.c2 = wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_S1, e1: RST_E1, s2: RST_S2, e2: RST_E2,
                      m1: FLOW_CHAIN, m2: FLOW_CHAIN, c1: 1'b0, c2: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign buf1_start = st_q.s1;
    assign buf1_end   = st_q.e1;
    assign buf2_start = st_q.s2;
    assign buf2_end   = st_q.e2;
    assign buf1_mode  = st_q.m1;
    assign buf2_mode  = st_q.m2;
    assign clr_eob1   = st_q.c1;
    assign clr_eob2   = st_q.c2;

    bcr_rdmux #(.PW(PW), .DW(DW)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_rd (acc_rd),
        .sel    (sel),
        .s1     (st_q.s1),
        .e1     (st_q.e1),
        .s2     (st_q.s2),
        .e2     (st_q.e2),
        .m1     (st_q.m1),
        .m2     (st_q.m2),
        .f1     (eob1_flag),
        .f2     (eob2_flag),
        .rdata  (rdata)
    );

    AST_CLR1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_eob1 |-> $past(!cmd_n && ce && !rd_wr && cmd_addr == C_FLAG && !lb_n && wdata[0])); // R4
    AST_CLR2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_eob2 |-> $past(!cmd_n && ce && !rd_wr && cmd_addr == C_FLAG && !lb_n && wdata[1])); // R4
    AST_CFG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!cmd_n && ce && !rd_wr) |->
            ($stable({buf1_start, buf1_end, buf2_start, buf2_end, buf1_mode, buf2_mode})
             && !clr_eob1 && !clr_eob2)); // R1
    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_n && ce && !rd_wr && cmd_addr[2:1] == 2'b11) |->
            $stable({buf1_start, buf1_end, buf2_start, buf2_end, buf1_mode, buf2_mode})); // R6
    AST_CLR_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_n && ce && !rd_wr && cmd_addr == C_FLAG) |->
            $stable({buf1_start, buf1_end, buf2_start, buf2_end, buf1_mode, buf2_mode})); // R4
endmodule

// File: tb/tb_bcr_top.sv
module tb_bcr_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_n = 1'b1, ce = 1'b0, rd_wr = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [2:0]  cmd_addr = '0;
    logic [15:0] wdata = '0;
    logic        eob1_flag = 1'b0, eob2_flag = 1'b0;
    logic [15:0] rdata;
    logic [12:0] buf1_start, buf1_end, buf2_start, buf2_end;
    logic [1:0]  buf1_mode, buf2_mode;
    logic        clr_eob1, clr_eob2;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [12:0] ms1, me1, ms2, me2;
    logic [1:0]  mm1, mm2;
    logic        mc1, mc2;

    bcr_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .ce(ce), .rd_wr(rd_wr),
        .cmd_addr(cmd_addr), .lb_n(lb_n), .ub_n(ub_n), .wdata(wdata),
        .rdata(rdata), .eob1_flag(eob1_flag), .eob2_flag(eob2_flag),
        .buf1_start(buf1_start), .buf1_end(buf1_end), .buf2_start(buf2_start),
        .buf2_end(buf2_end), .buf1_mode(buf1_mode), .buf2_mode(buf2_mode),
        .clr_eob1(clr_eob1), .clr_eob2(clr_eob2)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] m_merge(input logic [12:0] old, input logic [15:0] wd,
                                            input logic lo_n, input logic hi_n);
        logic [12:0] r = old;
        for (int i = 0; i < 13; i++)
            if ((i < 8) ? !lo_n : !hi_n) r[i] = wd[i];
        return r;
    endfunction

    function automatic logic [15:0] exp_rd();
        logic [15:0] r = 16'hFFFF;
        if (!cmd_n && ce && rd_wr) begin
            case (cmd_addr)
                3'd0: r[12:0] = ms1;
                3'd1: r[12:0] = me1;
                3'd2: r[12:0] = ms2;
                3'd3: r[12:0] = me2;
                3'd4: r[3:0]  = {mm2, mm1};
                3'd5: r[1:0]  = {eob2_flag, eob1_flag};
                default: r = 16'hFFFF;
            endcase
        end
        return r;
    endfunction

    task automatic model_reset();
        ms1 = 13'd0; me1 = 13'd4095; ms2 = 13'd4096; me2 = 13'd8191;
        mm1 = 2'b00; mm2 = 2'b00; mc1 = 0; mc2 = 0;
    endtask

    task automatic model_edge();
        mc1 = 0; mc2 = 0;
        if (!cmd_n && ce && !rd_wr) begin
            case (cmd_addr)
                3'd0: ms1 = m_merge(ms1, wdata, lb_n, ub_n);
                3'd1: me1 = m_merge(me1, wdata, lb_n, ub_n);
                3'd2: ms2 = m_merge(ms2, wdata, lb_n, ub_n);
                3'd3: me2 = m_merge(me2, wdata, lb_n, ub_n);
                3'd4: if (!lb_n) begin mm1 = wdata[1:0]; mm2 = wdata[3:2]; end
                3'd5: if (!lb_n) begin mc1 = wdata[0]; mc2 = wdata[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic chk_outs(input string req);
        chk(buf1_start, ms1, req); chk(buf1_end, me1, req);
        chk(buf2_start, ms2, req); chk(buf2_end, me2, req);
        chk({buf2_mode, buf1_mode}, {mm2, mm1}, req);
        chk({clr_eob2, clr_eob1}, {mc2, mc1}, req);
    endtask

    // Called just after a falling edge: drive, check read data, take the edge, check state.
    task automatic step(input logic cn, input logic c, input logic rw, input logic [2:0] a,
                        input logic l, input logic u, input logic [15:0] wd, input string req);
        cmd_n = cn; ce = c; rd_wr = rw; cmd_addr = a; lb_n = l; ub_n = u; wdata = wd;
        #1;
        chk(rdata, exp_rd(), req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk_outs(req);
    endtask

    task automatic idle(input string req);
        step(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 16'h0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        #(CLK_P * 2 + 2);
        @(negedge clk);
        chk_outs("R7 reset state");
        rst_n = 1'b1;
        idle("R7 idle after reset");

        // R2 full writes and reads of the boundary registers
        step(0, 1, 0, 3'd0, 0, 0, 16'hE123, "R2 write start1");
        step(0, 1, 0, 3'd3, 0, 0, 16'h1ABC, "R2 write end2");
        step(0, 1, 1, 3'd0, 1, 1, 16'h0, "R2 read start1");
        step(0, 1, 1, 3'd3, 1, 1, 16'h0, "R2 read end2");
        // R8 byte lanes
        step(0, 1, 0, 3'd1, 0, 1, 16'hFF5A, "R8 lower byte only");
        step(0, 1, 0, 3'd1, 1, 0, 16'h1700, "R8 upper byte only");
        step(0, 1, 0, 3'd1, 1, 1, 16'h0000, "R8 no byte enable");
        step(0, 1, 0, 3'd4, 1, 0, 16'hFFFF, "R8 flow needs lower byte");
        // R3 flow register
        step(0, 1, 0, 3'd4, 0, 0, 16'h00B6, "R3 flow write stop/linear");
        step(0, 1, 1, 3'd4, 1, 1, 16'h0, "R3 flow read");
        // R1 no access
        step(1, 1, 0, 3'd0, 0, 0, 16'h0000, "R1 strobe high write ignored");
        step(0, 0, 0, 3'd2, 0, 0, 16'h0000, "R1 ce low write ignored");
        step(0, 0, 1, 3'd4, 1, 1, 16'h0, "R1 ce low read ones");
        // R6 reserved
        step(0, 1, 0, 3'd6, 0, 0, 16'h0000, "R6 reserved write 6");
        step(0, 1, 0, 3'd7, 0, 0, 16'h0000, "R6 reserved write 7");
        step(0, 1, 1, 3'd7, 1, 1, 16'h0, "R6 reserved read");
        // R4 clear pulses, then overlap with a boundary write and a status read
        eob1_flag = 1; eob2_flag = 0;
        step(0, 1, 0, 3'd5, 0, 0, 16'h0003, "R4 clear both");
        step(0, 1, 0, 3'd2, 0, 0, 16'h0777, "R4 pulse ends during next write");
        step(0, 1, 1, 3'd5, 1, 1, 16'h0, "R5 status read");
        step(0, 1, 0, 3'd5, 0, 0, 16'h0002, "R4 clear flag2 only");
        step(0, 1, 0, 3'd5, 1, 0, 16'h0003, "R4 clear needs lower byte");
        idle("R4 pulse gone");

        // Random mix
        for (int k = 0; k < 600; k++) begin
            eob1_flag = 1'($urandom); eob2_flag = 1'($urandom);
            step(($urandom % 6) == 0, ($urandom % 6) != 0, 1'($urandom), 3'($urandom),
                 ($urandom % 4) == 0, ($urandom % 3) == 0, 16'($urandom), "R2 R3 R4 R5 R8 random");
        end

        // R9 asynchronous reset away from any edge
        step(0, 1, 0, 3'd1, 0, 0, 16'h0123, "R9 setup");
        #2 rst_n = 1'b0;
        #1 model_reset();
        chk(buf1_end, 13'd4095, "R9 async reset end1");
        chk({buf2_mode, buf1_mode}, 4'h0, "R9 async reset modes");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9 after release");
        finish_run();
    end
endmodule